// File: doc/BRIEF.md
# Reset Cause and Hard-Fault Flag Register

This block is an 8-bit status and control register. It records why the microcontroller last came out of reset, and it watches instruction fetches for addresses beyond the end of program flash. Reset events come from the reset controller as a one-cycle strobe with a 2-bit kind code. Each kind leaves its own mix of preserved, forced and cleared bits. A power-on reset, applied through the asynchronous `por_n` input, clears everything.

When a fetch is strobed and its address is greater than the last valid flash address, the block treats it as a hard fault. It handles the fault in one of three ways:
- If the fault-interrupt enable is high, it raises a level interrupt.
- Otherwise it sends one reset-request pulse to the reset controller.
- If the device is in debug mode with the debug enable low, it only records the fault, with no reset request.

A small state machine produces the reset request. Its states are `HS_IDLE`, `HS_REQ` and `HS_WAIT`. It moves from `HS_IDLE` to `HS_REQ` on a fault that needs a reset. It always moves from `HS_REQ` to `HS_WAIT` on the next cycle. It leaves `HS_WAIT` for `HS_IDLE` only when a reset event arrives. A reset event in any state returns it to `HS_IDLE`. Software reads the register on `rd_data` and writes it with `wr_en`/`wr_data`.

Top module: `aux_reset_cause_reg`

## Requirements
- R1: While `por_n` is low, `rd_data` is 8'h00, `hf_irq` is 0 and `hf_rst_req` is 0.
- R2: A reset event with kind 2'd0 (software) sets bit 7, keeps bit 6 and clears bits 5..0 on the next clock.
- R3: A reset event with kind 2'd1 (external pin) sets bit 6, keeps bit 7 and clears bits 5..0.
- R4: A reset event with kind 2'd2 (hard fault) sets bit 5, keeps bits 7..6 and clears bits 4..0.
- R5: A reset event with kind 2'd3 (any other source) keeps bits 7..5 and clears bits 4..0.
- R6: Suppose `fetch_valid` is high with `fetch_addr` greater than `FLASH_LAST`, `hf_int_en` is 0, and the debug override is not active. On the next clock, bit 5 is set and `hf_rst_req` goes high for exactly one cycle. An address equal to `FLASH_LAST` is not a fault.
- R7: The same fault with `hf_int_en` at 1 sets bit 4 and raises `hf_irq`, and gives no reset request.
- R8: The same fault with `hf_int_en` at 0, `dbg_mode` at 1 and `dbg_en` at 0 sets bit 5 only, and gives no reset request.
- R9: A write stores `wr_data` bits 7..3 and bit 0. Bits 2 and 1 always read 0, and writes to them are ignored.
- R10: If a hardware flag set and a software write to the same bit fall in one cycle, the flag ends up set.
- R11: After a reset request, no further request is issued until a reset event arrives.
- R12: `hf_irq` follows bit 4. A write of 0 to bit 4 drops the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_evt | input | 1 | One-cycle strobe: a reset of kind `rst_kind` was applied |
| rst_kind | input | 2 | Reset kind: 0 software, 1 pin, 2 hard fault, 3 other |
| fetch_valid | input | 1 | Fetch address strobe |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| hf_int_en | input | 1 | 1 routes faults to the interrupt, 0 to reset |
| dbg_mode | input | 1 | Device is in on-chip debug mode |
| dbg_en | input | 1 | Debug enable; 0 in debug mode suppresses fault resets |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data |
| rd_data | output | 8 | Register contents |
| hf_irq | output | 1 | Hard-fault interrupt level |
| hf_rst_req | output | 1 | One-cycle hard-fault reset request |

## Verification
The hardest case to reach is a fault that arrives while the request machine sits in `HS_WAIT`. A further fault there must set the flag but must not produce a second request. Reaching it takes a reset-requesting fault first, then more faults before any reset event.

The random phase gets there often:
- Reset events are rare, so the machine usually lingers in `HS_WAIT`.
- Fetch addresses cluster on both sides of the flash limit.
- Debug and enable levels change every cycle.

Directed cases pin down the exact boundary address and the write-versus-flag collisions.

// File: rtl/aux_cause_pkg.sv
package aux_cause_pkg;
    localparam int REG_W = 8;
    localparam int B_SWR = 7;
    localparam int B_PIN = 6;
    localparam int B_HFR = 5;
    localparam int B_HFI = 4;
    localparam logic [REG_W-1:0] WR_MASK = 8'b1111_1001;

    typedef enum logic [1:0] {
        RK_SOFT   = 2'd0,
        RK_PIN    = 2'd1,
        RK_HFAULT = 2'd2,
        RK_OTHER  = 2'd3
    } rst_kind_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_WAIT = 2'd2
    } hf_state_e;
endpackage

// File: rtl/aux_fetch_chk.sv
module aux_fetch_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] FLASH_LAST = ADDR_W'(32'h7FFF)
) (
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              hf_int_en,
    input  logic              dbg_mode,
    input  logic              dbg_en,
    output logic              fault_int,
    output logic              fault_rst,
    output logic              fault_quiet
);
    logic out_of_range;
    logic suppress;

    // strictly beyond the last valid address
    assign out_of_range = fetch_valid && (fetch_addr > FLASH_LAST);
    assign suppress     = dbg_mode && !dbg_en;

    assign fault_int   = out_of_range && hf_int_en;
    assign fault_quiet = out_of_range && !hf_int_en && suppress;
    assign fault_rst   = out_of_range && !hf_int_en && !suppress;
endmodule

// File: rtl/aux_rst_pattern.sv
module aux_rst_pattern
    import aux_cause_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  rst_kind_e        kind,
    output logic [REG_W-1:0] nxt
);
    always_comb begin
        unique case (kind)
            RK_SOFT:   nxt = {1'b1, cur[B_PIN], 6'b0};
            RK_PIN:    nxt = {cur[B_SWR], 1'b1, 6'b0};
            RK_HFAULT: nxt = {cur[B_SWR:B_PIN], 1'b1, 5'b0};
            RK_OTHER:  nxt = {cur[B_SWR:B_HFR], 5'b0};
            default:   nxt = '0;
        endcase
    end
endmodule

// File: rtl/aux_hf_req_fsm.sv
module aux_hf_req_fsm
    import aux_cause_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_evt,
    input  logic fault_rst,
    output logic rst_req
);
    hf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (fault_rst) state_d = HS_REQ;
            HS_REQ:  state_d = HS_WAIT;
            HS_WAIT: state_d = HS_WAIT;
            default: state_d = HS_IDLE;
        endcase
        if (rst_evt) state_d = HS_IDLE;
    end

    always_comb begin
        unique case (state_q)
            HS_REQ:  rst_req = 1'b1;
            default: rst_req = 1'b0;
        endcase
    end

    a_r6_req_single: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);
    a_r6_req_follows_fault: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == HS_IDLE && fault_rst && !rst_evt) |=> rst_req);
    a_r11_no_repeat: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == HS_WAIT && !rst_evt) |=> !rst_req);
endmodule

// File: rtl/aux_reset_cause_reg.sv
module aux_reset_cause_reg
    import aux_cause_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] FLASH_LAST = ADDR_W'(32'h7FFF)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_evt,
    input  logic [1:0]        rst_kind,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              hf_int_en,
    input  logic              dbg_mode,
    input  logic              dbg_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              hf_irq,
    output logic              hf_rst_req
);
    logic [REG_W-1:0] q, q_nxt, pat;
    logic fault_int, fault_rst, fault_quiet;
    rst_kind_e kind;

    assign kind = rst_kind_e'(rst_kind);

    aux_fetch_chk #(.ADDR_W(ADDR_W), .FLASH_LAST(FLASH_LAST)) u_chk (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .hf_int_en   (hf_int_en),
        .dbg_mode    (dbg_mode),
        .dbg_en      (dbg_en),
        .fault_int   (fault_int),
        .fault_rst   (fault_rst),
        .fault_quiet (fault_quiet)
    );

    aux_rst_pattern u_pat (
        .cur  (q),
        .kind (kind),
        .nxt  (pat)
    );

    aux_hf_req_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .rst_evt   (rst_evt),
        .fault_rst (fault_rst),
        .rst_req   (hf_rst_req)
    );

    // reset event beats everything; hardware sets beat software writes
    always_comb begin
        if (rst_evt) begin
            q_nxt = pat;
        end else begin
            q_nxt = wr_en ? (wr_data & WR_MASK) : q;
            if (fault_int)               q_nxt[B_HFI] = 1'b1;
            if (fault_rst || fault_quiet) q_nxt[B_HFR] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= q_nxt;
    end

    assign rd_data = q;
    assign hf_irq  = q[B_HFI];

    a_r2_soft_pattern: assert property (@(posedge clk) disable iff (!por_n)
        (rst_evt && rst_kind == 2'd0) |=>
            (rd_data[7] && rd_data[5:0] == 6'd0 && rd_data[6] == $past(rd_data[6])));
    a_r3_pin_pattern: assert property (@(posedge clk) disable iff (!por_n)
        (rst_evt && rst_kind == 2'd1) |=>
            (rd_data[6] && rd_data[5:0] == 6'd0 && rd_data[7] == $past(rd_data[7])));
    a_r4_hf_pattern: assert property (@(posedge clk) disable iff (!por_n)
        (rst_evt && rst_kind == 2'd2) |=>
            (rd_data[5] && rd_data[4:0] == 5'd0 && rd_data[7:6] == $past(rd_data[7:6])));
    a_r5_other_pattern: assert property (@(posedge clk) disable iff (!por_n)
        (rst_evt && rst_kind == 2'd3) |=>
            (rd_data[4:0] == 5'd0 && rd_data[7:5] == $past(rd_data[7:5])));
    a_r7_irq_raised: assert property (@(posedge clk) disable iff (!por_n)
        (fault_int && !rst_evt) |=> (hf_irq && !hf_rst_req));
    a_r8_quiet_no_req: assert property (@(posedge clk) disable iff (!por_n)
        (fault_quiet && !rst_evt) |=> (rd_data[5] && !hf_rst_req));
    a_r9_write_store: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !rst_evt && !fetch_valid) |=> rd_data == ($past(wr_data) & 8'hF9));
    a_r10_hw_wins: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && (fault_rst || fault_quiet) && !rst_evt) |=> rd_data[5]);
endmodule

// File: tb/aux_reset_cause_reg_bench.sv
module aux_reset_cause_reg_bench;
    localparam int AW = 16;
    localparam logic [AW-1:0] LAST = 16'h7FFF;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic por_n = 1'b0, evt = 1'b0, fv = 1'b0, ien = 1'b0, dm = 1'b0, de = 1'b0, wr = 1'b0;
    logic [1:0] kind = 2'd0;
    logic [AW-1:0] fa = '0;
    logic [7:0] wd = '0;
    logic [7:0] rd_data;
    logic hf_irq, hf_rst_req;

    int total = 0, bad = 0;
    logic done = 1'b0;
    logic [7:0] exp_q = 8'h00;
    int exp_st = 0;

    aux_reset_cause_reg #(.ADDR_W(AW), .FLASH_LAST(LAST)) u_aux_reset_cause_reg (
        .clk(clk), .por_n(por_n), .rst_evt(evt), .rst_kind(kind),
        .fetch_valid(fv), .fetch_addr(fa), .hf_int_en(ien), .dbg_mode(dm),
        .dbg_en(de), .wr_en(wr), .wr_data(wd), .rd_data(rd_data),
        .hf_irq(hf_irq), .hf_rst_req(hf_rst_req));

    function automatic logic [7:0] f_next_q(input logic [7:0] c);
        logic [7:0] v;
        logic flt;
        flt = fv && (fa > LAST);
        if (evt) begin
            case (kind)
                2'd0: v = {1'b1, c[6], 6'b0};
                2'd1: v = {c[7], 1'b1, 6'b0};
                2'd2: v = {c[7:6], 1'b1, 5'b0};
                default: v = {c[7:5], 5'b0};
            endcase
        end else begin
            v = wr ? (wd & 8'hF9) : c;
            if (flt && ien)  v[4] = 1'b1;
            if (flt && !ien) v[5] = 1'b1;
        end
        return v;
    endfunction

    function automatic int f_next_st(input int s);
        logic need;
        need = fv && (fa > LAST) && !ien && !(dm && !de);
        if (evt) return 0;
        if (s == 0) return need ? 1 : 0;
        return 2;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        logic [7:0] nq;
        int ns;
        nq = f_next_q(exp_q);
        ns = f_next_st(exp_st);
        @(posedge clk); #1;
        exp_q = nq;
        exp_st = ns;
        chk("model rd_data R9", {24'd0, rd_data}, {24'd0, exp_q});
        chk("model irq R12", {31'd0, hf_irq}, {31'd0, exp_q[4]});
        chk("model req R11", {31'd0, hf_rst_req}, {31'd0, logic'(exp_st == 1)});
    endtask

    task automatic do_write(input logic [7:0] d);
        wr = 1'b1; wd = d; cyc(); wr = 1'b0;
    endtask

    task automatic do_evt(input logic [1:0] k);
        evt = 1'b1; kind = k; cyc(); evt = 1'b0;
    endtask

    task automatic do_fetch(input logic [AW-1:0] a);
        fv = 1'b1; fa = a; cyc(); fv = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset rd_data", {24'd0, rd_data}, 32'h00);
        chk("R1 reset irq", {31'd0, hf_irq}, 32'd0);
        chk("R1 reset req", {31'd0, hf_rst_req}, 32'd0);
        por_n = 1'b1;

        do_write(8'hFF); chk("R9 write ff", {24'd0, rd_data}, 32'hF9);
        do_write(8'h0A); chk("R9 bit1 ignored", {24'd0, rd_data}, 32'h08);

        do_write(8'h48); do_evt(2'd0); chk("R2 soft", {24'd0, rd_data}, 32'hC0);
        do_write(8'h09); do_evt(2'd1); chk("R3 pin", {24'd0, rd_data}, 32'h40);
        do_write(8'h80); do_evt(2'd1); chk("R3 pin keeps b7", {24'd0, rd_data}, 32'hC0);
        do_write(8'hF9); do_evt(2'd2); chk("R4 hard fault", {24'd0, rd_data}, 32'hE0);
        do_write(8'hB8); do_evt(2'd3); chk("R5 other", {24'd0, rd_data}, 32'hA0);

        do_write(8'h00);
        do_fetch(LAST); chk("R6 boundary no fault", {23'd0, hf_rst_req, rd_data}, 32'h000);
        do_fetch(LAST + 16'd1); chk("R6 fault", {23'd0, hf_rst_req, rd_data}, 32'h120);
        cyc(); chk("R6 pulse ends", {31'd0, hf_rst_req}, 32'd0);
        do_fetch(16'hFFFF); chk("R11 no second req", {31'd0, hf_rst_req}, 32'd0);
        do_evt(2'd2);
        do_fetch(16'h9000); chk("R11 req after event", {31'd0, hf_rst_req}, 32'd1);
        do_evt(2'd2);

        do_write(8'h00); ien = 1'b1;
        do_fetch(16'h8000); chk("R7 irq", {22'd0, hf_irq, hf_rst_req, rd_data}, 32'h210);
        do_write(8'h00); chk("R12 irq cleared", {31'd0, hf_irq}, 32'd0);
        wr = 1'b1; wd = 8'h00; do_fetch(16'h8001); wr = 1'b0;
        chk("R10 bit4 wins", {24'd0, rd_data}, 32'h10);
        ien = 1'b0;

        do_write(8'h00); dm = 1'b1; de = 1'b0;
        do_fetch(16'h8000); chk("R8 quiet", {23'd0, hf_rst_req, rd_data}, 32'h020);
        cyc(); chk("R8 still no req", {31'd0, hf_rst_req}, 32'd0);
        wr = 1'b1; wd = 8'h00; do_fetch(16'h8002); wr = 1'b0;
        chk("R10 bit5 wins", {24'd0, rd_data}, 32'h20);
        de = 1'b1;
        do_fetch(16'h8000); chk("R8 debug enabled resets", {31'd0, hf_rst_req}, 32'd1);
        dm = 1'b0; de = 1'b0;
        do_evt(2'd3);

        for (int i = 0; i < 3000; i++) begin
            evt  = ($urandom % 20) == 0;
            kind = 2'($urandom);
            wr   = ($urandom % 4) == 0;
            wd   = 8'($urandom);
            fv   = ($urandom % 3) == 0;
            fa   = ($urandom % 2 == 0) ? (LAST - AW'($urandom % 4)) : (LAST + AW'($urandom % 4));
            ien  = 1'($urandom);
            dm   = ($urandom % 4) == 0;
            de   = 1'($urandom);
            cyc();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule